// File: doc/BRIEF.md
# Vector Float to Unsigned 64-bit Integer Converter

This block takes a 128-bit source vector that holds four single-precision floating-point words and converts the two even-numbered words into unsigned 64-bit integers. Each integer lands in one doubleword half of a 128-bit result. The fractional part is always dropped, so every conversion truncates toward zero. No other rounding mode exists inside the block.

A conversion starts with a one-cycle `issue` pulse. One clock later the block presents the registered result, a write-enable and a set of flag pulses. The flags report an invalid conversion, a signaling NaN and an inexact result. Two exception-enable inputs can turn an inexact outcome into a trap request. A trap from either lane suppresses the whole write, and the result register keeps its previous contents.

Top module: `vcvt_f2u64`

## Requirements
- R1: Source word n occupies bits 32n+31:32n. Word 0 converts into result bits 63:0 and word 2 converts into result bits 127:64. Words 1 and 3 have no effect on any output.
- R2: A positive normal input below 2^64 yields floor(x). An exact input raises no flag. An input with a nonzero fraction raises the inexact flag.
- R3: A quiet NaN (exponent all ones, fraction bit 22 set) yields 0 and raises the invalid flag only.
- R4: A signaling NaN (exponent all ones, fraction bit 22 clear, fraction nonzero) yields 0 and raises both the invalid flag and the signaling-NaN flag.
- R5: An input less than or equal to -1.0, including -infinity, yields 0 and raises the invalid flag.
- R6: An input strictly between -1.0 and 0 yields 0 and raises inexact. If `en_invalid` is high, it also raises `trap_req`.
- R7: A positive inexact conversion with `en_inexact` high raises `trap_req`. An exact conversion never traps.
- R8: An input at or above 2^64, including +infinity, yields 0xFFFF_FFFF_FFFF_FFFF and raises the invalid flag.
- R9: Zero of either sign yields 0 with no flag. A denormal yields 0 and raises inexact. A positive denormal traps only under `en_inexact`, and a negative denormal traps only under `en_invalid`.
- R10: The flag outputs are the OR of both lanes. When either lane traps, `result_we` stays low and `result` keeps its prior value.
- R11: The outputs respond exactly one cycle after `issue`. In a cycle that follows no issue, `result_we`, all flags and `trap_req` are low and `result` is unchanged.
- R12: While reset is asserted, `result` is zero and every single-bit output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Starts a conversion of `src` this cycle |
| src | input | 128 | Four single-precision words |
| en_invalid | input | 1 | Trap enable for the negative-fraction case |
| en_inexact | input | 1 | Trap enable for the positive inexact case |
| result | output | 128 | Two unsigned 64-bit integers |
| result_we | output | 1 | Result was written this cycle |
| flag_invalid | output | 1 | Invalid-conversion pulse |
| flag_snan | output | 1 | Signaling-NaN pulse |
| flag_inexact | output | 1 | Inexact pulse |
| trap_req | output | 1 | Trap request; the write was suppressed |

## Verification
All state sits in a single output register stage. A wrong next-state value therefore shows up at the ports exactly one cycle after the `issue` that caused it, with nothing hidden behind later stages. If the result register loads during a suppressed write, it shows a changed `result` in that same cycle and a wrong value on every later idle cycle. The directed scenarios pair each lane with a different class of input, so a lane swap, or a flag that is not ORed across lanes, changes the observed vector.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int SP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = 127;
    localparam int INT_W  = 64;
    localparam int SIG_W  = FRAC_W + 1;
    localparam int EXPU_W = EXP_W + 2;
    localparam int SH_W   = $clog2(INT_W);

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DENORM,
        CL_NORMAL,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } fp_class_e;

    typedef struct packed {
        logic [INT_W-1:0] val;
        logic             inv;
        logic             snan;
        logic             inexact;
        logic             trap;
    } lane_out_t;
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
    import fcvt_pkg::*;
(
    input  logic [SP_W-1:0]          word,
    output fp_class_e                cls,
    output logic                     sign,
    output logic signed [EXPU_W-1:0] exp_unb,
    output logic [SIG_W-1:0]         sig
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign sign   = word[SP_W-1];
    assign exp_f  = word[SP_W-2 -: EXP_W];
    assign frac_f = word[FRAC_W-1:0];

    // Unbiased exponent; meaningful only for normal inputs.
    assign exp_unb = $signed({2'b00, exp_f}) - $signed(EXPU_W'(BIAS));
    assign sig     = {1'b1, frac_f};

    always_comb begin
        if (exp_f == '1) begin
            if (frac_f == '0)          cls = CL_INF;
            else if (frac_f[FRAC_W-1]) cls = CL_QNAN;
            else                       cls = CL_SNAN;
        end else if (exp_f == '0) begin
            cls = (frac_f == '0) ? CL_ZERO : CL_DENORM;
        end else begin
            cls = CL_NORMAL;
        end
    end
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  logic [SIG_W-1:0] sig,
    input  logic [SH_W-1:0]  shamt,
    output logic [INT_W-1:0] mag,
    output logic             lost
);
    localparam int WIDE_W = INT_W + FRAC_W;

    logic [WIDE_W-1:0] wide;

    // Binary point sits between bits FRAC_W and FRAC_W-1 of the wide value.
    assign wide = {{(WIDE_W-SIG_W){1'b0}}, sig} << shamt;
    assign mag  = wide[WIDE_W-1:FRAC_W];
    assign lost = |wide[FRAC_W-1:0];
endmodule

// File: rtl/fcvt_lane.sv
module fcvt_lane
    import fcvt_pkg::*;
(
    input  logic [SP_W-1:0] word,
    input  logic            en_invalid,
    input  logic            en_inexact,
    output lane_out_t       lane_o
);
    localparam logic signed [EXPU_W-1:0] LIM = EXPU_W'(INT_W);

    fp_class_e                cls;
    logic                     sign;
    logic signed [EXPU_W-1:0] exp_unb;
    logic [SIG_W-1:0]         sig;
    logic [INT_W-1:0]         mag;
    logic                     lost;

    fcvt_classify u_cls (
        .word    (word),
        .cls     (cls),
        .sign    (sign),
        .exp_unb (exp_unb),
        .sig     (sig)
    );

    fcvt_align u_aln (
        .sig   (sig),
        .shamt (exp_unb[SH_W-1:0]),
        .mag   (mag),
        .lost  (lost)
    );

    always_comb begin
        lane_o = '0;
        unique case (cls)
            CL_QNAN: lane_o.inv = 1'b1;
            CL_SNAN: begin
                lane_o.inv  = 1'b1;
                lane_o.snan = 1'b1;
            end
            CL_INF: begin
                lane_o.inv = 1'b1;
                lane_o.val = sign ? '0 : '1;
            end
            CL_ZERO: ;
            CL_DENORM: begin
                lane_o.inexact = 1'b1;
                lane_o.trap    = sign ? en_invalid : en_inexact;
            end
            CL_NORMAL: begin
                if (sign) begin
                    if (exp_unb >= 0) begin
                        lane_o.inv = 1'b1;
                    end else begin
                        lane_o.inexact = 1'b1;
                        lane_o.trap    = en_invalid;
                    end
                end else if (exp_unb >= LIM) begin
                    lane_o.inv = 1'b1;
                    lane_o.val = '1;
                end else if (exp_unb < 0) begin
                    lane_o.inexact = 1'b1;
                    lane_o.trap    = en_inexact;
                end else begin
                    lane_o.val     = mag;
                    lane_o.inexact = lost;
                    lane_o.trap    = lost & en_inexact;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vcvt_f2u64.sv
module vcvt_f2u64
    import fcvt_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  issue,
    input  logic [LANES*2*SP_W-1:0] src,
    input  logic                  en_invalid,
    input  logic                  en_inexact,
    output logic [LANES*INT_W-1:0] result,
    output logic                  result_we,
    output logic                  flag_invalid,
    output logic                  flag_snan,
    output logic                  flag_inexact,
    output logic                  trap_req
);
    localparam int RES_W = LANES * INT_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             we;
        logic             inv;
        logic             snan;
        logic             inx;
        logic             trap;
    } state_t;

    state_t    st_d, st_q;
    lane_out_t lane_o [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // Lane k reads the even word 2k of the source.
        fcvt_lane u_lane (
            .word       (src[(2*k)*SP_W +: SP_W]),
            .en_invalid (en_invalid),
            .en_inexact (en_inexact),
            .lane_o     (lane_o[k])
        );
    end

    always_comb begin
        logic [RES_W-1:0] res_n;
        logic inv_n, snan_n, inx_n, trap_n;
        res_n  = '0;
        inv_n  = 1'b0;
        snan_n = 1'b0;
        inx_n  = 1'b0;
        trap_n = 1'b0;
        for (int k = 0; k < LANES; k++) begin
            res_n[k*INT_W +: INT_W] = lane_o[k].val;
            inv_n  |= lane_o[k].inv;
            snan_n |= lane_o[k].snan;
            inx_n  |= lane_o[k].inexact;
            trap_n |= lane_o[k].trap;
        end
        st_d      = st_q;
        st_d.we   = 1'b0;
        st_d.inv  = 1'b0;
        st_d.snan = 1'b0;
        st_d.inx  = 1'b0;
        st_d.trap = 1'b0;
        if (issue) begin
            st_d.inv  = inv_n;
            st_d.snan = snan_n;
            st_d.inx  = inx_n;
            st_d.trap = trap_n;
            st_d.we   = ~trap_n;
            if (!trap_n) st_d.res = res_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result       = st_q.res;
    assign result_we    = st_q.we;
    assign flag_invalid = st_q.inv;
    assign flag_snan    = st_q.snan;
    assign flag_inexact = st_q.inx;
    assign trap_req     = st_q.trap;
endmodule

// File: rtl/vcvt_f2u64_chk.sv
module vcvt_f2u64_chk #(
    parameter int RES_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic             en_invalid,
    input logic             en_inexact,
    input logic [RES_W-1:0] result,
    input logic             result_we,
    input logic             flag_invalid,
    input logic             flag_snan,
    input logic             flag_inexact,
    input logic             trap_req
);
    p_we_not_trap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> !result_we);

    p_hold_on_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !result_we |-> $stable(result));

    p_snan_is_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_snan |-> flag_invalid);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !(result_we | flag_invalid | flag_snan | flag_inexact | trap_req));

    p_issue_responds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (result_we | trap_req));

    p_trap_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        issue && !en_invalid && !en_inexact |=> !trap_req);

    p_trap_is_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> flag_inexact);
endmodule

bind vcvt_f2u64 vcvt_f2u64_chk #(.RES_W(LANES*fcvt_pkg::INT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (issue),
    .en_invalid   (en_invalid),
    .en_inexact   (en_inexact),
    .result       (result),
    .result_we    (result_we),
    .flag_invalid (flag_invalid),
    .flag_snan    (flag_snan),
    .flag_inexact (flag_inexact),
    .trap_req     (trap_req)
);

// File: tb/sim_vcvt_f2u64.sv
module sim_vcvt_f2u64;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue = 1'b0;
    logic [127:0] src = '0;
    logic         en_invalid = 1'b0;
    logic         en_inexact = 1'b0;
    logic [127:0] result;
    logic         result_we, flag_invalid, flag_snan, flag_inexact, trap_req;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    vcvt_f2u64 u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .src(src),
        .en_invalid(en_invalid), .en_inexact(en_inexact),
        .result(result), .result_we(result_we),
        .flag_invalid(flag_invalid), .flag_snan(flag_snan),
        .flag_inexact(flag_inexact), .trap_req(trap_req)
    );

    task automatic check(input string req, input logic [127:0] e_res,
                         input logic [4:0] e_bits);
        logic [4:0] a_bits;
        a_bits = {result_we, flag_invalid, flag_snan, flag_inexact, trap_req};
        n_vec++;
        if (result !== e_res || a_bits !== e_bits) begin
            n_bad++;
            $display("FAIL %s: result=%h we/inv/snan/inx/trap=%b expected result=%h bits=%b",
                     req, result, a_bits, e_res, e_bits);
        end
    endtask

    // Drive one issue at a falling edge, sample at the next falling edge.
    task automatic apply(input logic [31:0] w3, input logic [31:0] w2,
                         input logic [31:0] w1, input logic [31:0] w0,
                         input logic ei, input logic ex);
        @(negedge clk);
        src = {w3, w2, w1, w0};
        en_invalid = ei;
        en_inexact = ex;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic t_reset;
        check("R12", '0, 5'b00000);
    endtask

    task automatic t_lanes;
        // Odd words hold NaNs; they must not raise invalid.
        apply(32'h7FC0_0000, 32'h3F80_0000, 32'h7F80_0001, 32'h4B80_0000, 1'b0, 1'b0);
        check("R1", {64'd1, 64'h100_0000}, 5'b10000);
    endtask

    task automatic t_trunc;
        apply(32'h0, 32'h5F7F_FFFF, 32'h0, 32'h42C9_8000, 1'b0, 1'b0);
        check("R2", {64'hFFFF_FF00_0000_0000, 64'd100}, 5'b10010);
        apply(32'h0, 32'h4020_0000, 32'h0, 32'h3F00_0000, 1'b0, 1'b0);
        check("R2", {64'd2, 64'd0}, 5'b10010);
    endtask

    task automatic t_big;
        apply(32'h0, 32'h5F80_0000, 32'h0, 32'h5F00_0000, 1'b0, 1'b0);
        check("R8", {ONES, 64'h8000_0000_0000_0000}, 5'b11000);
        apply(32'h0, 32'hFF80_0000, 32'h0, 32'h7F80_0000, 1'b0, 1'b0);
        check("R8", {64'd0, ONES}, 5'b11000);
    endtask

    task automatic t_nan;
        apply(32'h0, 32'h3F80_0000, 32'h0, 32'h7FC0_0000, 1'b0, 1'b0);
        check("R3", {64'd1, 64'd0}, 5'b11000);
        apply(32'h0, 32'h7F80_0001, 32'h0, 32'h3F80_0000, 1'b0, 1'b0);
        check("R4", {64'd0, 64'd1}, 5'b11100);
    endtask

    task automatic t_neg;
        apply(32'h0, 32'hC2C9_8000, 32'h0, 32'hBF80_0000, 1'b1, 1'b1);
        check("R5", '0, 5'b11000);
    endtask

    task automatic t_negfrac;
        apply(32'h0, 32'h3F80_0000, 32'h0, 32'hBF00_0000, 1'b0, 1'b0);
        check("R6", {64'd1, 64'd0}, 5'b10010);
        apply(32'h0, 32'h4000_0000, 32'h0, 32'hBF00_0000, 1'b1, 1'b0);
        check("R6", {64'd1, 64'd0}, 5'b00011);
    endtask

    task automatic t_inexact_trap;
        apply(32'h0, 32'h4B80_0000, 32'h0, 32'h4000_0000, 1'b0, 1'b1);
        check("R7", {64'h100_0000, 64'd2}, 5'b10000);
        apply(32'h0, 32'h4000_0000, 32'h0, 32'h4020_0000, 1'b0, 1'b1);
        check("R10", {64'h100_0000, 64'd2}, 5'b00011);
        apply(32'h0, 32'h4020_0000, 32'h0, 32'h4000_0000, 1'b1, 1'b0);
        check("R7", {64'd2, 64'd2}, 5'b10010);
    endtask

    task automatic t_zero_denorm;
        apply(32'h0, 32'h0000_0000, 32'h0, 32'h8000_0000, 1'b1, 1'b1);
        check("R9", '0, 5'b10000);
        apply(32'h0, 32'h3F80_0000, 32'h0, 32'h0000_0001, 1'b1, 1'b0);
        check("R9", {64'd1, 64'd0}, 5'b10010);
        apply(32'h0, 32'h8000_0001, 32'h0, 32'h3F80_0000, 1'b0, 1'b1);
        check("R9", {64'd0, 64'd1}, 5'b10010);
        apply(32'h0, 32'h4000_0000, 32'h0, 32'h0000_0001, 1'b0, 1'b1);
        check("R9", {64'd0, 64'd1}, 5'b00011);
    endtask

    task automatic t_idle;
        apply(32'h0, 32'h4000_0000, 32'h0, 32'h4040_0000, 1'b0, 1'b0);
        check("R11", {64'd2, 64'd3}, 5'b10000);
        src = {32'h0, 32'h7FC0_0000, 32'h0, 32'hBF00_0000};
        en_invalid = 1'b1;
        @(negedge clk);
        check("R11", {64'd2, 64'd3}, 5'b00000);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_lanes();
        t_trunc();
        t_big();
        t_nan();
        t_neg();
        t_negfrac();
        t_inexact_trap();
        t_zero_denorm();
        t_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule